// File: doc/BRIEF.md
# Battery Pack Switch Control

This block decides the levels of the three pack switch drivers (charge, discharge and pre-charge) and tracks whether the pack is in power-down. Each driver output is active high and means "switch off". A host controller writes a 3-bit switch code and a 3-bit regulator code through two decoded write strobes that share one data bus. Two override pins from the host can force switches off at any time, and they win over the stored code. A charger-detect input and a regulator-good flag steer the way out of power-down.

The power logic is a three-state machine. `ST_RUN` is normal operation. The transition `go_down` leaves `ST_RUN` (or `ST_WAKE`) for `ST_DOWN` when an accepted regulator write carries the regulator-off code while no charger is present. The transition `go_wake` leaves `ST_DOWN` for `ST_WAKE` when charger-detect goes high; the regulator is turned back on at 3.3 V there. The transition `go_run` leaves `ST_WAKE` for `ST_RUN` on the first host write made while the regulator-good flag is high. The power-down flag is high in `ST_DOWN` and `ST_WAKE` and tells neighbouring blocks to idle their outputs. The stored switch code is cleared when `go_down` fires. In the other states the code is kept while an override is active.

Top module: `psw_ctrl`

## Requirements
- R1: After reset, `chg_off`, `dis_off` and `pre_off` are 1, `reg_sel` is 2'b00 (3.3 V), `reg_en` is 1 and `pwr_down` is 0.
- R2: In `ST_RUN`, a `sw_wr` with data code C sets the outputs from the cycle after the write: `chg_off` = ~C[2], `dis_off` = ~C[1], `pre_off` = ~C[0]. So code 000 turns all three off and code 111 turns all three on.
- R3: While `ovr_dis` is 1, `dis_off` is 1 in the same cycle, whatever the stored code.
- R4: While `ovr_chg` is 1, `chg_off` and `pre_off` are 1 in the same cycle, whatever the stored code. `dis_off` is unaffected.
- R5: When an override is released, the outputs return to the levels set by the stored switch code. An override does not change the stored code.
- R6: In `ST_RUN`, a `reg_wr` with code 000 or 011 sets `reg_sel` to 2'b00 (3.3 V), and code 010 sets it to 2'b10 (5.0 V). The change shows from the next cycle, and `reg_en` stays 1.
- R7: A `reg_wr` whose code has bit 2 set (1xx) leaves `reg_sel` unchanged.
- R8: In `ST_RUN`, a `reg_wr` with code 001 while `chg_detect` is 0 enters `ST_DOWN` from the next cycle. There `pwr_down` is 1, `reg_en` is 0, `reg_sel` is 2'b01 and all three switch outputs are 1.
- R9: A `reg_wr` with code 001 while `chg_detect` is 1 has no effect: `pwr_down` stays 0, `reg_en` stays 1 and the switch outputs keep their levels.
- R10: In `ST_DOWN`, host writes are ignored and the state holds until `chg_detect` is 1. One cycle later the block is in `ST_WAKE`: `reg_en` is 1, `reg_sel` is 2'b00, while `pwr_down` and all switch outputs stay 1.
- R11: In `ST_WAKE`, host writes are ignored while `reg_good` is 0. A write made with `reg_good` at 1 takes effect and returns the block to `ST_RUN`, so `pwr_down` is 0 from the next cycle.
- R12: Entering `ST_DOWN` clears the stored switch code. After the return to `ST_RUN` through a regulator write, all three switch outputs stay 1 until a new `sw_wr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr | input | 1 | Strobe: write the switch code from `cmd_data` |
| reg_wr | input | 1 | Strobe: write the regulator code from `cmd_data` |
| cmd_data | input | 3 | Code written by the strobes |
| ovr_chg | input | 1 | Host override: forces the charge and pre-charge switches off |
| ovr_dis | input | 1 | Host override: forces the discharge switch off |
| chg_detect | input | 1 | Charger present |
| reg_good | input | 1 | Regulator output is in range |
| chg_off | output | 1 | Charge switch driver, 1 = off |
| dis_off | output | 1 | Discharge switch driver, 1 = off |
| pre_off | output | 1 | Pre-charge switch driver, 1 = off |
| reg_sel | output | 2 | Regulator mode: 00 = 3.3 V, 01 = off, 10 = 5.0 V |
| reg_en | output | 1 | Regulator enabled |
| pwr_down | output | 1 | Power-down flag for neighbouring blocks |

## Verification
Writes and charger-detect changes go through exactly one register, so their results are due in the cycle after the edge that samples them. The override pins are purely combinational and show in the same cycle. The bench drives every input at a falling edge. It checks registered results at the next falling edge, after one rising edge, and checks override results a nanosecond after it drives the pin, before any rising edge. Tests for ignored writes read the outputs during the cycle after the write, then issue one more write to confirm the stored state.

// File: rtl/psw_pkg.sv
package psw_pkg;

    localparam int CODE_W = 3;
    localparam int SEL_W  = 2;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_DOWN = 2'd1,
        ST_WAKE = 2'd2
    } pwr_state_t;

    typedef enum logic [SEL_W-1:0] {
        VSEL_3V3 = 2'b00,
        VSEL_OFF = 2'b01,
        VSEL_5V0 = 2'b10
    } vsel_t;

    // regulator command values (bit 2 set = ignored)
    localparam logic [CODE_W-1:0] RCMD_OFF = 3'b001;
    localparam logic [1:0]        RLOW_OFF = 2'b01;
    localparam logic [1:0]        RLOW_5V0 = 2'b10;

endpackage

// File: rtl/psw_pwr_fsm.sv
module psw_pwr_fsm
    import psw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  logic              reg_wr,
    input  logic [CODE_W-1:0] cmd_data,
    input  logic              chg_detect,
    input  logic              reg_good,
    output logic              accept,
    output logic              go_down,
    output logic              go_wake,
    output logic              pwr_down
);

    pwr_state_t state_q, state_d;
    logic       any_wr;

    assign any_wr = sw_wr | reg_wr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // transitions and strobes
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        go_down = 1'b0;
        go_wake = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                accept  = 1'b1;
                go_down = reg_wr && (cmd_data == RCMD_OFF) && !chg_detect;
                if (go_down) state_d = ST_DOWN;
            end
            ST_DOWN: begin
                go_wake = chg_detect;
                if (go_wake) state_d = ST_WAKE;
            end
            ST_WAKE: begin
                accept  = reg_good;
                go_down = reg_good && reg_wr && (cmd_data == RCMD_OFF) && !chg_detect;
                if (go_down)              state_d = ST_DOWN;
                else if (accept && any_wr) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // flag output
    always_comb begin
        pwr_down = (state_q != ST_RUN);
    end

endmodule

// File: rtl/psw_cmd_regs.sv
module psw_cmd_regs
    import psw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  logic              reg_wr,
    input  logic [CODE_W-1:0] cmd_data,
    input  logic              accept,
    input  logic              go_down,
    input  logic              go_wake,
    output logic [CODE_W-1:0] sw_code,
    output vsel_t             reg_sel
);

    // switch code: reset and power-down entry both mean "all off"
    always_ff @(posedge clk) begin
        if (!rst_n)                sw_code <= '0;
        else if (go_down)          sw_code <= '0;
        else if (accept && sw_wr)  sw_code <= cmd_data;
    end

    // regulator mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_sel <= VSEL_3V3;
        end else if (go_down) begin
            reg_sel <= VSEL_OFF;
        end else if (go_wake) begin
            reg_sel <= VSEL_3V3;
        end else if (accept && reg_wr && !cmd_data[CODE_W-1]) begin
            unique case (cmd_data[1:0])
                RLOW_5V0: reg_sel <= VSEL_5V0;
                RLOW_OFF: reg_sel <= reg_sel;
                default:  reg_sel <= VSEL_3V3;
            endcase
        end
    end

endmodule

// File: rtl/psw_drive.sv
module psw_drive
    import psw_pkg::*;
(
    input  logic [CODE_W-1:0] sw_code,
    input  logic              force_off,
    input  logic              ovr_chg,
    input  logic              ovr_dis,
    output logic              chg_off,
    output logic              dis_off,
    output logic              pre_off
);

    logic [CODE_W-1:0] base_off;
    logic [CODE_W-1:0] ovr_vec;

    // per-bit override vector: bit2 charge, bit1 discharge, bit0 pre-charge
    assign ovr_vec = {ovr_chg, ovr_dis, ovr_chg};

    for (genvar b = 0; b < CODE_W; b++) begin : g_bit
        assign base_off[b] = force_off | ~sw_code[b] | ovr_vec[b];
    end

    assign chg_off = base_off[2];
    assign dis_off = base_off[1];
    assign pre_off = base_off[0];

endmodule

// File: rtl/psw_ctrl.sv
module psw_ctrl
    import psw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  logic              reg_wr,
    input  logic [CODE_W-1:0] cmd_data,
    input  logic              ovr_chg,
    input  logic              ovr_dis,
    input  logic              chg_detect,
    input  logic              reg_good,
    output logic              chg_off,
    output logic              dis_off,
    output logic              pre_off,
    output logic [SEL_W-1:0]  reg_sel,
    output logic              reg_en,
    output logic              pwr_down
);

    logic              accept;
    logic              go_down;
    logic              go_wake;
    logic [CODE_W-1:0] sw_code;
    vsel_t             sel_q;

    psw_pwr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_wr      (sw_wr),
        .reg_wr     (reg_wr),
        .cmd_data   (cmd_data),
        .chg_detect (chg_detect),
        .reg_good   (reg_good),
        .accept     (accept),
        .go_down    (go_down),
        .go_wake    (go_wake),
        .pwr_down   (pwr_down)
    );

    psw_cmd_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_wr    (sw_wr),
        .reg_wr   (reg_wr),
        .cmd_data (cmd_data),
        .accept   (accept),
        .go_down  (go_down),
        .go_wake  (go_wake),
        .sw_code  (sw_code),
        .reg_sel  (sel_q)
    );

    psw_drive u_drive (
        .sw_code   (sw_code),
        .force_off (pwr_down),
        .ovr_chg   (ovr_chg),
        .ovr_dis   (ovr_dis),
        .chg_off   (chg_off),
        .dis_off   (dis_off),
        .pre_off   (pre_off)
    );

    assign reg_sel = sel_q;
    assign reg_en  = (sel_q != VSEL_OFF);

endmodule

// File: rtl/psw_ctrl_chk.sv
module psw_ctrl_chk
    import psw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sw_wr,
    input logic              reg_wr,
    input logic [CODE_W-1:0] cmd_data,
    input logic              ovr_chg,
    input logic              ovr_dis,
    input logic              chg_detect,
    input logic              chg_off,
    input logic              dis_off,
    input logic              pre_off,
    input logic [SEL_W-1:0]  reg_sel,
    input logic              reg_en,
    input logic              pwr_down
);

    // R3
    dis_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_dis |-> dis_off);

    // R4
    chg_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_chg |-> (chg_off && pre_off));

    // R7
    reg_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_down && reg_wr && cmd_data[CODE_W-1]) |=> $stable(reg_sel));

    // R8
    enter_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_down && reg_wr && cmd_data == RCMD_OFF && !chg_detect)
        |=> (pwr_down && !reg_en));

    // R9
    down_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_down && reg_wr && cmd_data == RCMD_OFF && chg_detect)
        |=> (!pwr_down && reg_en));

    // R10
    down_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> (chg_off && dis_off && pre_off));

endmodule

bind psw_ctrl psw_ctrl_chk i_psw_ctrl_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_wr      (sw_wr),
    .reg_wr     (reg_wr),
    .cmd_data   (cmd_data),
    .ovr_chg    (ovr_chg),
    .ovr_dis    (ovr_dis),
    .chg_detect (chg_detect),
    .chg_off    (chg_off),
    .dis_off    (dis_off),
    .pre_off    (pre_off),
    .reg_sel    (reg_sel),
    .reg_en     (reg_en),
    .pwr_down   (pwr_down)
);

// File: tb/test_psw_ctrl.sv
`timescale 1ns/1ps
module test_psw_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_wr = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] cmd_data = 3'b000;
    logic       ovr_chg = 1'b0;
    logic       ovr_dis = 1'b0;
    logic       chg_detect = 1'b0;
    logic       reg_good = 1'b1;
    logic       chg_off, dis_off, pre_off, reg_en, pwr_down;
    logic [1:0] reg_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    psw_ctrl i_psw_ctrl (
        .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .reg_wr(reg_wr),
        .cmd_data(cmd_data), .ovr_chg(ovr_chg), .ovr_dis(ovr_dis),
        .chg_detect(chg_detect), .reg_good(reg_good),
        .chg_off(chg_off), .dis_off(dis_off), .pre_off(pre_off),
        .reg_sel(reg_sel), .reg_en(reg_en), .pwr_down(pwr_down)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int sw3();
        return {chg_off, dis_off, pre_off};
    endfunction

    task automatic write_sw(input logic [2:0] c);
        @(negedge clk); sw_wr = 1'b1; cmd_data = c;
        @(negedge clk); sw_wr = 1'b0;
    endtask

    task automatic write_reg(input logic [2:0] c);
        @(negedge clk); reg_wr = 1'b1; cmd_data = c;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 switches", sw3(), 3'b111);
        chk("R1 reg_sel", reg_sel, 2'b00);
        chk("R1 reg_en", reg_en, 1);
        chk("R1 pwr_down", pwr_down, 0);
    endtask

    task automatic t_codes();
        for (int c = 0; c < 8; c++) begin
            write_sw(3'(c));
            chk("R2 code map", sw3(), (~c) & 7);
        end
    endtask

    task automatic t_override();
        write_sw(3'b111);
        chk("R2 all on", sw3(), 3'b000);
        @(negedge clk); ovr_dis = 1'b1; #1;
        chk("R3 dis forced", sw3(), 3'b010);
        @(negedge clk); ovr_dis = 1'b0; #1;
        chk("R5 dis released", sw3(), 3'b000);
        @(negedge clk); ovr_chg = 1'b1; #1;
        chk("R4 chg forced", sw3(), 3'b101);
        write_sw(3'b010);
        chk("R4 chg still forced", sw3(), 3'b101);
        @(negedge clk); ovr_chg = 1'b0; #1;
        chk("R5 code kept under override", sw3(), 3'b101 & ~3'b000 & 3'b101);
        write_sw(3'b111);
    endtask

    task automatic t_reg();
        write_reg(3'b010);
        chk("R6 5v0", reg_sel, 2'b10);
        chk("R6 enabled", reg_en, 1);
        write_reg(3'b100);
        chk("R7 100 ignored", reg_sel, 2'b10);
        write_reg(3'b111);
        chk("R7 111 ignored", reg_sel, 2'b10);
        write_reg(3'b011);
        chk("R6 011 to 3v3", reg_sel, 2'b00);
        write_reg(3'b010);
        write_reg(3'b000);
        chk("R6 000 to 3v3", reg_sel, 2'b00);
    endtask

    task automatic t_pd_blocked();
        write_sw(3'b110);
        @(negedge clk); chg_detect = 1'b1;
        write_reg(3'b001);
        chk("R9 no power-down", pwr_down, 0);
        chk("R9 reg_en", reg_en, 1);
        chk("R9 switches kept", sw3(), 3'b001);
        @(negedge clk); chg_detect = 1'b0;
    endtask

    task automatic t_pd_cycle();
        write_sw(3'b111);
        write_reg(3'b001);
        chk("R8 pwr_down", pwr_down, 1);
        chk("R8 reg_en", reg_en, 0);
        chk("R8 reg_sel", reg_sel, 2'b01);
        chk("R8 switches off", sw3(), 3'b111);
        write_sw(3'b111);
        chk("R10 write ignored", sw3(), 3'b111);
        write_reg(3'b010);
        chk("R10 reg write ignored", reg_sel, 2'b01);
        @(negedge clk); chg_detect = 1'b1;
        @(negedge clk);
        chk("R10 wake reg_en", reg_en, 1);
        chk("R10 wake reg_sel", reg_sel, 2'b00);
        chk("R10 wake flag", pwr_down, 1);
        chk("R10 wake switches", sw3(), 3'b111);
        reg_good = 1'b0;
        write_reg(3'b010);
        chk("R11 not good flag", pwr_down, 1);
        chk("R11 not good sel", reg_sel, 2'b00);
        reg_good = 1'b1;
        write_reg(3'b000);
        chk("R11 back to run", pwr_down, 0);
        chk("R12 code cleared", sw3(), 3'b111);
        write_sw(3'b111);
        chk("R11 run switch write", sw3(), 3'b000);
        @(negedge clk); chg_detect = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_codes();
        t_override();
        t_reg();
        t_pd_blocked();
        t_pd_cycle();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule